// File: doc/BRIEF.md
# SPI command-stream sequencer

This block is an SPI controller that is steered by a stream of 16-bit instruction words instead of by a fixed transfer register. Each word is one of five actions: move a run of bytes on the bus, drive the chip-select lines and then wait, load an internal register (clock divider or bus configuration), idle for a timed interval, or publish a sync marker. Transmit bytes arrive on one stream, received bytes leave on another, and software knows that a program has finished when its sync marker appears.

All three streams use valid/ready handshakes. A word or byte moves on a rising clock edge where both valid and ready are high. `cmd_ready` and `rx_valid` come only from registered state. `tx_ready` also depends on `rx_ready`. No ready depends on the matching valid. The sequencer waits before a byte if that byte needs transmit data and none is offered. It also waits if the byte will produce a received byte while the previous received byte is still held and not being taken. While it waits, SCLK stays at its rest level. `rx_valid` stays high, with `rx_data` unchanged, until the byte is taken.

Instruction layout: bits 15:12 opcode, bits 11:8 argument A, bits 7:0 argument B. Opcode 0 is a transfer. In A, bit 0 means write and bit 1 means read. B+1 bytes move. Opcode 1 drives the chip-select lines with mask B, then waits, with A setting the delay. Opcode 2 writes register A with B: A=0 is the divider, and A=1 is the configuration, with B bit 0 = CPHA, bit 1 = CPOL and bit 2 = three-wire. Opcode 3 with A=0 is a sync carrying marker B. Opcode 3 with A=1 is a sleep of length B.

Top module: `spiseq_top`

## Requirements
- R1: Any other opcode (4 to 15), opcode 3 with A other than 0 or 1, and opcode 2 with a target other than 0 or 1 change nothing. Like a register write, each of these takes one cycle, and the next word is accepted on the following edge.
- R2: A register write takes effect on the edge that accepts it. `three_wire` shows configuration bit 2. The next word is accepted one cycle later.
- R3: One SCLK half period lasts divider+1 clock cycles. Each byte takes one setup cycle, followed by 16 half periods.
- R4: SCLK rests at CPOL. Bytes shift MSB first. With CPHA=0, SDO is valid from the start of the byte, SDI is sampled on each leading edge and SDO changes on each trailing edge. With CPHA=1, SDO changes on each leading edge and SDI is sampled on each trailing edge.
- R5: A transfer moves B+1 bytes. With the write flag set, it takes one transmit byte per byte. With the flag clear, it takes none and sends zeros. With the read flag set, it delivers one received byte per byte. With the flag clear, it delivers none. After the last byte, one cycle passes before the next word is accepted.
- R6: A chip-select instruction drives `cs_n` to mask B on the accepting edge, where a 0 bit selects a device. The block then waits 2·(A+1)·(divider+1) cycles and one further fetch cycle before accepting the next word.
- R7: A sleep holds SCLK at rest for 2·(B+1)·(divider+1) cycles plus one fetch cycle.
- R8: A sync sets `sync_id` to B on the accepting edge. `sync_pulse` is high for exactly the following cycle.
- R9: A byte with the write flag set does not start while no transmit byte is offered. SCLK stays at rest until a byte is offered.
- R10: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds steady, and the next read byte does not start.
- R11: After reset, `cs_n` is all ones, SCLK is low, divider and configuration are zero, `sync_id` is 0, `rx_valid` and `sync_pulse` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Instruction word offered |
| cmd_ready | output | 1 | Sequencer accepts an instruction word |
| cmd_data | input | 16 | Instruction word |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Sequencer takes a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | SPI clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| cs_n | output | CS_N | Active-low chip selects |
| three_wire | output | 1 | Three-wire mode flag from configuration |
| sync_pulse | output | 1 | One-cycle sync event |
| sync_id | output | 8 | Last published sync marker |

## Verification
The hardest states to reach from the ports are the two stalls inside a transfer. In one, a write byte finds the transmit stream empty. In the other, a read byte finds the previous received byte still unconsumed. Both occur only between bytes of a running instruction, so the bench leaves the transmit stream empty, or holds `rx_ready` low, across a multi-byte transfer and then releases it. It checks that SCLK stays at rest and that the held byte stays unchanged during the wait. The bench ties SDI to SDO, to its inverse or to a constant, so every mode's sampling edge shows up in the received bytes.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  localparam int CMD_W  = 16;
  localparam int ARG_W  = 8;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_XFER = 4'd0;
  localparam logic [3:0] OP_CSEL = 4'd1;
  localparam logic [3:0] OP_WREG = 4'd2;
  localparam logic [3:0] OP_MISC = 4'd3;

  localparam logic [3:0] REG_DIV = 4'd0;
  localparam logic [3:0] REG_CFG = 4'd1;
  localparam logic [3:0] SUB_SYNC  = 4'd0;
  localparam logic [3:0] SUB_SLEEP = 4'd1;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_WAIT  = 2'd3
  } state_e;

  typedef struct packed {
    logic three;
    logic cpol;
    logic cpha;
  } cfg_t;
endpackage

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/spiseq_shift.sv
module spiseq_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              tick,
  input  logic              cpha,
  input  logic              sdi,
  output logic              sdo,
  output logic              phase,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EC_W  = $clog2(EDGES);
  localparam logic [EC_W-1:0] LAST = EC_W'(EDGES - 1);

  logic [BYTE_W-1:0] tx_sh_q, rx_sh_q;
  logic [EC_W-1:0]   ecnt_q;
  logic              sdo_q, ph_q;
  logic              sample_now, shift_now;

  assign sample_now = tick && (ecnt_q[0] == cpha);
  assign shift_now  = tick && (ecnt_q[0] != cpha) && !(!cpha && ecnt_q == LAST);
  assign done       = tick && (ecnt_q == LAST);
  assign rx_byte    = cpha ? {rx_sh_q[BYTE_W-2:0], sdi} : rx_sh_q;
  assign sdo        = sdo_q;
  assign phase      = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      ecnt_q  <= '0;
      sdo_q   <= 1'b0;
      ph_q    <= 1'b0;
    end else if (load) begin
      ecnt_q <= '0;
      ph_q   <= 1'b0;
      if (cpha) begin
        tx_sh_q <= load_data;
      end else begin
        tx_sh_q <= {load_data[BYTE_W-2:0], 1'b0};
        sdo_q   <= load_data[BYTE_W-1];
      end
    end else if (tick) begin
      ph_q   <= ~ph_q;
      ecnt_q <= ecnt_q + 1'b1;
      if (sample_now) rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sdi};
      if (shift_now) begin
        sdo_q   <= tx_sh_q[BYTE_W-1];
        tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CS_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [CS_N-1:0]   cs_n,
  output logic              three_wire,
  output logic              sync_pulse,
  output logic [ARG_W-1:0]  sync_id
);
  localparam int CNT_W = ARG_W + 2;

  state_e            st_q;
  cfg_t              cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [CS_N-1:0]   cs_q;
  logic              wr_q, rd_q;
  logic [ARG_W-1:0]  left_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic              sync_q;
  logic [ARG_W-1:0]  id_q;
  logic              rxv_q;
  logic [BYTE_W-1:0] rxd_q;

  logic [3:0]        op, arg_a;
  logic [ARG_W-1:0]  arg_b;
  logic              accept, rx_free, start_ok, tick, run, done, phase;
  logic [BYTE_W-1:0] rx_byte, load_data;

  assign op     = cmd_data[15:12];
  assign arg_a  = cmd_data[11:8];
  assign arg_b  = cmd_data[7:0];

  assign cmd_ready = (st_q == ST_FETCH);
  assign accept    = cmd_valid && cmd_ready;
  assign rx_free   = !rxv_q || rx_ready;
  assign tx_ready  = (st_q == ST_SETUP) && wr_q && (!rd_q || rx_free);
  assign start_ok  = (st_q == ST_SETUP) && (!wr_q || tx_valid) && (!rd_q || rx_free);
  assign run       = (st_q == ST_SHIFT) || (st_q == ST_WAIT);
  assign load_data = wr_q ? tx_data : '0;

  spiseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div_q),
    .tick (tick)
  );

  spiseq_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ok),
    .load_data(load_data),
    .tick     (tick && st_q == ST_SHIFT),
    .cpha     (cfg_q.cpha),
    .sdi      (sdi),
    .sdo      (sdo),
    .phase    (phase),
    .done     (done),
    .rx_byte  (rx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_FETCH;
      cfg_q  <= '0;
      div_q  <= '0;
      cs_q   <= '1;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      left_q <= '0;
      wcnt_q <= '0;
      sync_q <= 1'b0;
      id_q   <= '0;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      sync_q <= 1'b0;
      if (rxv_q && rx_ready) rxv_q <= 1'b0;
      unique case (st_q)
        ST_FETCH: begin
          if (accept) begin
            unique case (op)
              OP_XFER: begin
                wr_q   <= arg_a[0];
                rd_q   <= arg_a[1];
                left_q <= arg_b;
                st_q   <= ST_SETUP;
              end
              OP_CSEL: begin
                cs_q   <= arg_b[CS_N-1:0];
                wcnt_q <= CNT_W'({arg_a, 1'b0}) + CNT_W'(2);
                st_q   <= ST_WAIT;
              end
              OP_WREG: begin
                if (arg_a == REG_DIV) div_q <= DIV_W'(arg_b);
                if (arg_a == REG_CFG) cfg_q <= arg_b[2:0];
              end
              OP_MISC: begin
                if (arg_a == SUB_SYNC) begin
                  id_q   <= arg_b;
                  sync_q <= 1'b1;
                end
                if (arg_a == SUB_SLEEP) begin
                  wcnt_q <= CNT_W'({arg_b, 1'b0}) + CNT_W'(2);
                  st_q   <= ST_WAIT;
                end
              end
              default: ;
            endcase
          end
        end
        ST_SETUP: begin
          if (start_ok) st_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (done) begin
            if (rd_q) begin
              rxd_q <= rx_byte;
              rxv_q <= 1'b1;
            end
            if (left_q == '0) begin
              st_q <= ST_FETCH;
            end else begin
              left_q <= left_q - 1'b1;
              st_q   <= ST_SETUP;
            end
          end
        end
        ST_WAIT: begin
          if (tick) begin
            wcnt_q <= wcnt_q - 1'b1;
            if (wcnt_q == CNT_W'(1)) st_q <= ST_FETCH;
          end
        end
        default: st_q <= ST_FETCH;
      endcase
    end
  end

  assign sclk       = phase ^ cfg_q.cpol;
  assign cs_n       = cs_q;
  assign three_wire = cfg_q.three;
  assign sync_pulse = sync_q;
  assign sync_id    = id_q;
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;

  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SHIFT) |-> (sclk == cfg_q.cpol));
  p_sync_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(accept && op == OP_MISC && arg_a == SUB_SYNC));
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  p_cs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT || st_q == ST_SETUP) |=> $stable(cs_n));
  p_tx_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETUP && wr_q && !tx_valid) |=> (st_q == ST_SETUP));
endmodule

// File: tb/sim_spiseq_top.sv
`timescale 1ns/100ps
module sim_spiseq_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [15:0] cmd_data = '0;
  logic [7:0] tx_data = '0;
  logic cmd_ready, tx_ready, rx_valid, sclk, sdo, sdi, three_wire, sync_pulse;
  logic [7:0] rx_data, cs_n, sync_id;

  always #2 clk = ~clk;

  int sdi_mode = 0;
  assign sdi = (sdi_mode == 0) ? sdo : (sdi_mode == 1) ? ~sdo : 1'b1;

  spiseq_top u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n), .three_wire(three_wire),
    .sync_pulse(sync_pulse), .sync_id(sync_id)
  );

  logic [15:0] cmdq[$];
  logic [7:0]  txq[$], mtx[$], exp_rx[$], got_rx[$];
  int e_main[$], e_sdo[$];
  string e_tag[$];
  int m_cpol = 0, m_cpha = 0, m_three = 0, m_div = 0, m_cs = 255, m_id = 0;
  int checks = 0, fails = 0, cycles = 0;
  bit cmp_en = 0, rdy_en = 1, pend_cmd = 0, pend_tx = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_s(int s, int c, int d, int y, string t);
    e_main.push_back((y << 9) | (s << 8) | c);
    e_sdo.push_back(d);
    e_tag.push_back(t);
  endtask

  task automatic push_idle(int n, string t);
    for (int i = 0; i < n; i++) push_s(m_cpol, m_cs, -1, 0, t);
  endtask

  task automatic gen_span(logic [15:0] c);
    int op, a, b, hp, t, d, bv;
    op = c[15:12]; a = c[11:8]; b = c[7:0];
    hp = m_div + 1;
    case (op)
      0: begin
        if (!cmp_en) return;
        for (int k = 0; k <= b; k++) begin
          bv = a[0] ? mtx.pop_front() : 0;
          push_s(m_cpol, m_cs, -1, 0, "R3");
          for (int j = 0; j < 16 * hp; j++) begin
            t = j / hp;
            if (m_cpha == 0) d = (bv >> (7 - t / 2)) & 1;
            else d = (t == 0) ? -1 : ((bv >> (7 - (t - 1) / 2)) & 1);
            push_s(m_cpol ^ (t % 2), m_cs, d, 0, "R4");
          end
          if (a[1]) exp_rx.push_back(sdi_mode == 0 ? bv[7:0] : sdi_mode == 1 ? ~bv[7:0] : 8'hFF);
        end
        push_idle(1, "R5");
      end
      1: begin m_cs = b; push_idle(2 * (a + 1) * hp + 1, "R6"); end
      2: begin
        if (a == 0) m_div = b;
        if (a == 1) begin m_cpha = b & 1; m_cpol = (b >> 1) & 1; m_three = (b >> 2) & 1; end
        push_idle(1, (a < 2) ? "R2" : "R1");
      end
      3: begin
        if (a == 0) begin m_id = b; push_s(m_cpol, m_cs, -1, 1, "R8"); end
        else if (a == 1) push_idle(2 * (b + 1) * hp + 1, "R7");
        else push_idle(1, "R1");
      end
      default: push_idle(1, "R1");
    endcase
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (pend_cmd) gen_span(cmdq.pop_front());
      if (pend_tx) void'(txq.pop_front());
      if (rst_n && cmp_en) begin
        int em, ed; string tg;
        if (e_main.size() > 0) begin
          em = e_main.pop_front(); ed = e_sdo.pop_front(); tg = e_tag.pop_front();
        end else begin
          em = (m_cpol << 8) | m_cs; ed = -1; tg = "R4";
        end
        chk({sync_pulse, sclk, cs_n} == em[9:0], tg, "sync/sclk/cs_n", {sync_pulse, sclk, cs_n}, em);
        if (ed >= 0) chk(sdo == ed[0], tg, "sdo", sdo, ed);
        chk(sync_id == m_id[7:0], "R8", "sync_id", sync_id, m_id);
        chk(three_wire == m_three[0], "R2", "three_wire", three_wire, m_three);
      end
      cmd_valid = cmdq.size() > 0;
      cmd_data  = cmd_valid ? cmdq[0] : 16'h0;
      tx_valid  = txq.size() > 0;
      tx_data   = tx_valid ? txq[0] : 8'h0;
      rx_ready  = rdy_en;
      #1;
      pend_cmd = cmd_valid && cmd_ready;
      pend_tx  = tx_valid && tx_ready;
      if (rx_valid && rx_ready) got_rx.push_back(rx_data);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic send(logic [15:0] c); cmdq.push_back(c); endtask
  task automatic give(logic [7:0] b); txq.push_back(b); mtx.push_back(b); endtask

  task automatic drain;
    while (cmdq.size() > 0 || e_main.size() > 0 || pend_cmd) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  task automatic rx_check(string tag);
    chk(got_rx.size() == exp_rx.size(), tag, "rx count", got_rx.size(), exp_rx.size());
    for (int i = 0; i < exp_rx.size() && i < got_rx.size(); i++)
      chk(got_rx[i] == exp_rx[i], tag, "rx byte", got_rx[i], exp_rx[i]);
    got_rx.delete(); exp_rx.delete();
  endtask

  initial begin
    int highs, moved;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk(cs_n == 8'hFF, "R11", "cs_n", cs_n, 8'hFF);
    chk(sclk == 1'b0, "R11", "sclk", sclk, 0);
    chk(!rx_valid && !sync_pulse, "R11", "rx_valid/sync_pulse", {rx_valid, sync_pulse}, 0);
    chk(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);
    chk(sync_id == 8'h00 && three_wire == 1'b0, "R11", "sync_id/three_wire", {three_wire, sync_id}, 0);
    cmp_en = 1;

    // mode 0, fastest clock, loopback, select, two-byte duplex, sync, release
    sdi_mode = 0;
    send(16'h2100); send(16'h2000); send(16'h10FE);
    give(8'h3C); give(8'hA5);
    send(16'h0301); send(16'h3011); send(16'h12FF);
    drain; rx_check("R5");

    // CPHA=1, divider 2, inverted return, three bytes
    sdi_mode = 1;
    send(16'h2101); send(16'h2002); send(16'h10FD);
    give(8'h81); give(8'h7E); give(8'h00);
    send(16'h0302);
    drain; rx_check("R4");

    // CPOL=1 CPHA=1, read-only zeros out, then write-only with no rx
    sdi_mode = 2;
    send(16'h2103); send(16'h2001);
    send(16'h0200);
    give(8'h5A); send(16'h0100);
    drain; rx_check("R5");

    // three-wire flag, CPOL=1 CPHA=0, sleep, ignored words, sync
    send(16'h2106); give(8'hC3); send(16'h0100);
    send(16'h3103); send(16'h5ABC); send(16'h3200); send(16'h2533);
    send(16'h30FE);
    drain; rx_check("R1");

    // long chip-select delay at divider 3
    send(16'h2003); send(16'h1F7F); send(16'h3001);
    drain;

    // R9: write byte waits for transmit data
    sdi_mode = 0;
    send(16'h2100); send(16'h2001);
    drain;
    cmp_en = 0;
    send(16'h0300);
    highs = 0;
    repeat (20) begin @(posedge clk); #1; if (sclk != 1'b0) highs++; end
    chk(highs == 0, "R9", "sclk edges while starved", highs, 0);
    chk(tx_ready == 1'b1, "R9", "tx_ready while waiting", tx_ready, 1);
    txq.push_back(8'h96); exp_rx.push_back(8'h96);
    repeat (60) @(posedge clk);
    rx_check("R9");

    // R10: held received byte blocks the next read byte
    sdi_mode = 2; rdy_en = 0;
    send(16'h0201);
    repeat (60) @(posedge clk); #1;
    chk(rx_valid == 1'b1 && rx_data == 8'hFF, "R10", "held byte", {rx_valid, rx_data}, 9'h1FF);
    highs = 0; moved = 0;
    repeat (20) begin
      @(posedge clk); #1;
      if (sclk != 1'b0) highs++;
      if (!rx_valid || rx_data != 8'hFF) moved++;
    end
    chk(highs == 0, "R10", "sclk edges while held", highs, 0);
    chk(moved == 0, "R10", "held byte changed", moved, 0);
    rdy_en = 1;
    exp_rx.push_back(8'hFF); exp_rx.push_back(8'hFF);
    repeat (60) @(posedge clk);
    rx_check("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule